// File: doc/BRIEF.md
# Serial Identification Page Read Engine

This block is the target side of a four-wire serial link. It answers a single read command against a 256-byte auxiliary page. The page is held in an internal register array. A parallel preload port fills that array, for example from a test or boot sequencer. The block does not program the page, lock it, or provide status.

The serial pins (clock, active-low select, data in) are oversampled by the system clock through two-stage synchronizers. The clock is idle low, input data is taken on its rising edge, and output data changes on its falling edge. A transaction carries:

- an eight-bit opcode, sent most significant bit first;
- then a 24-bit address, also most significant bit first.

If the command is accepted, the byte at address bits 7..0 is shifted out most significant bit first. Further bytes follow with no gap, and the byte address steps by one after each byte until select rises. A busy input stands for a write cycle in progress.

The controller is a five-state machine:

- `ST_IDLE`: select high. A low select moves it to `ST_CMD`.
- `ST_CMD`: collects eight opcode bits. After the eighth bit it moves to `ST_ADDR` if the opcode is 0x83 and busy is low. Otherwise it moves to `ST_REJECT`.
- `ST_ADDR`: collects 24 address bits. After the last one it moves to `ST_DATA` if address bit 10 is 0, else to `ST_REJECT`.
- `ST_DATA`: streams page bytes.
- `ST_REJECT`: keeps the output released.

A high select returns every state to `ST_IDLE`.

Top module: `idpg_responder`

## Requirements
- R1: After reset the output enable is low and the engine waits in idle.
- R2: The engine accepts opcode 0x83 followed by a 24-bit address, both MSB first. It returns the page byte at address bits 7..0, MSB first, with the first bit driven on the falling clock edge after the 32nd rising edge.
- R3: While select stays low, the next byte follows the previous one with no idle bit, at the byte address plus one.
- R4: The byte address wraps from 255 to 0 when a read runs past the end of the page.
- R5: Address bits 23..11 and 9..8 have no effect on the data returned.
- R6: With address bit 10 equal to 1, the output stays released for the rest of that select period.
- R7: Any opcode other than 0x83 leaves the output released for the rest of that select period.
- R8: The busy input is sampled only on the eighth rising clock edge. If it is high then, the command is rejected. Busy at any other time has no effect.
- R9: The output enable is low during the opcode and address phases.
- R10: Raising select releases the output at once, at any bit position. The next select period starts again with opcode decoding.
- R11: Input data is taken on rising clock edges. Output data changes only after falling clock edges and holds across the rising edge.
- R12: A write on the preload port replaces the addressed page byte, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| wip_busy | input | 1 | High while a write cycle is in progress |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 8 | Preload byte address |
| pre_data | input | 8 | Preload byte value |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |

## Verification
The assertions assume that the serial clock and select change no faster than the synchronizers can follow. They also assume the serial clock is low whenever select moves, so every edge seen inside a select period belongs to that period. The stimulus holds each serial clock level for four system clocks and moves select only while the serial clock is low. Busy changes only between bit slots, and preload writes happen only while select is high. Under these conditions the assertions on output release, reject stickiness, address stepping and output stability between falling edges are valid.

// File: rtl/idpg_pkg.sv
package idpg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_REJECT
    } idpg_state_e;
endpackage

// File: rtl/idpg_sync.sv
module idpg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/idpg_edge.sv
module idpg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/idpg_page.sv
module idpg_page #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/idpg_responder.sv
module idpg_responder
    import idpg_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         CMD_W       = 8,
    parameter int         ADDR_BITS   = 24,
    parameter int         LOCK_BIT    = 10,
    parameter int         PAGE_AW     = 8,
    parameter int         DW          = 8,
    parameter logic [7:0] OPCODE      = 8'h83
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    input  logic               wip_busy,
    input  logic               pre_we,
    input  logic [PAGE_AW-1:0] pre_addr,
    input  logic [DW-1:0]      pre_data,
    output logic               spi_miso,
    output logic               spi_miso_oe
);
    localparam int CNT_W = $clog2(CMD_W + ADDR_BITS);
    localparam int IDX_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(CMD_W + ADDR_BITS - 1);
    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(DW - 1);

    logic sclk_s, cs_s, mosi_s, sck_rise, sck_fall;

    idpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .din(spi_sclk), .dout(sclk_s));
    idpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .din(spi_cs_n), .dout(cs_s));
    idpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .din(spi_mosi), .dout(mosi_s));

    idpg_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise(sck_rise), .fall(sck_fall));

    idpg_state_e          state_q, state_d;
    logic [CNT_W-1:0]     bitcnt_q;
    logic [LOCK_BIT-1:0]  shreg_q, shreg_d;
    logic [PAGE_AW-1:0]   byte_addr_q;
    logic [IDX_W-1:0]     bit_idx_q;
    logic [DW-1:0]        page_rd;
    logic                 drive_q, miso_q;

    idpg_page #(.AW(PAGE_AW), .DW(DW)) u_page (
        .clk(clk), .we(pre_we), .waddr(pre_addr), .wdata(pre_data),
        .raddr(byte_addr_q), .rdata(page_rd));

    // Shifted view including the bit arriving on this edge.
    assign shreg_d = {shreg_q[LOCK_BIT-2:0], mosi_s};

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!cs_s) state_d = ST_CMD;
            ST_CMD: begin
                if (cs_s) state_d = ST_IDLE;
                else if (sck_rise && bitcnt_q == LAST_CMD)
                    state_d = (shreg_d[7:0] == OPCODE && !wip_busy) ? ST_ADDR : ST_REJECT;
            end
            ST_ADDR: begin
                if (cs_s) state_d = ST_IDLE;
                else if (sck_rise && bitcnt_q == LAST_ADDR)
                    state_d = shreg_q[LOCK_BIT-1] ? ST_REJECT : ST_DATA;
            end
            ST_DATA:   if (cs_s) state_d = ST_IDLE;
            ST_REJECT: if (cs_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Receive shifter, bit counter and byte pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q    <= '0;
            shreg_q     <= '0;
            byte_addr_q <= '0;
            bit_idx_q   <= TOP_IDX;
        end else begin
            if (state_q == ST_IDLE) begin
                bitcnt_q <= '0;
                shreg_q  <= '0;
            end else if ((state_q == ST_CMD || state_q == ST_ADDR) && sck_rise) begin
                bitcnt_q <= bitcnt_q + 1'b1;
                shreg_q  <= shreg_d;
            end
            if (state_q == ST_ADDR && state_d == ST_DATA) begin
                byte_addr_q <= shreg_d[PAGE_AW-1:0];
                bit_idx_q   <= TOP_IDX;
            end else if (state_q == ST_DATA && !cs_s && sck_fall) begin
                if (bit_idx_q == '0) begin
                    bit_idx_q   <= TOP_IDX;
                    byte_addr_q <= byte_addr_q + 1'b1;
                end else begin
                    bit_idx_q <= bit_idx_q - 1'b1;
                end
            end
        end
    end

    // Output register: updated only on falling edges in the data state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            miso_q  <= 1'b0;
        end else if (state_d != ST_DATA) begin
            drive_q <= 1'b0;
        end else if (state_q == ST_DATA && sck_fall) begin
            drive_q <= 1'b1;
            miso_q  <= page_rd[bit_idx_q];
        end
    end

    assign spi_miso    = miso_q;
    assign spi_miso_oe = drive_q & ~spi_cs_n;

    assert_oe_only_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q |-> state_q == ST_DATA);
    assert_release_on_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !drive_q);
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !cs_s && sck_fall && bit_idx_q == '0)
        |=> byte_addr_q == $past(byte_addr_q) + 1'b1);
    assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REJECT && !cs_s) |=> state_q == ST_REJECT);
    assert_miso_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !sck_fall) |=> $stable(miso_q));
    assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && !cs_s && sck_rise && bitcnt_q == LAST_CMD && wip_busy)
        |=> state_q == ST_REJECT);
endmodule

// File: tb/tb_idpg_responder.sv
module tb_idpg_responder;
    localparam int H = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
    logic pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;
    logic miso, oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] page_m [256];

    idpg_responder dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .wip_busy(busy), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .spi_miso(miso), .spi_miso_oe(oe));

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // One bit slot: drive, sample before rise, sample again before fall.
    task automatic bit_xfer(input logic din, output logic dout, output logic doe,
                            output logic steady);
        logic pre_rise;
        mosi = din;
        repeat (H) @(negedge clk);
        pre_rise = miso;
        doe = oe;
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        steady = (miso === pre_rise);
        dout = pre_rise;
        sclk = 1'b0;
    endtask

    task automatic preload(input int a, input logic [7:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = 8'(a); pre_data = v;
        @(negedge clk);
        pre_we = 1'b0;
        page_m[a] = v;
    endtask

    // Select low, opcode and address; busy_cmd during opcode, busy_addr afterwards.
    task automatic header(input logic [7:0] op, input logic [23:0] addr,
                          input logic busy_cmd, input logic busy_addr, input string tag);
        logic [31:0] w;
        int oe_hits;
        logic d, e, s;
        w = {op, addr};
        oe_hits = 0;
        cs_n = 1'b0;
        busy = busy_cmd;
        repeat (H) @(negedge clk);
        for (int i = 31; i >= 0; i--) begin
            if (i == 23) busy = busy_addr;
            bit_xfer(w[i], d, e, s);
            if (e) oe_hits++;
        end
        chk(oe_hits == 0, {tag, " R9 oe during header"}, oe_hits, 0);
    endtask

    task automatic read_check(input int start, input int n, input string tag);
        logic [7:0] got;
        int miss, unsteady;
        logic d, e, s;
        for (int k = 0; k < n; k++) begin
            miss = 0; unsteady = 0;
            for (int b = 7; b >= 0; b--) begin
                bit_xfer(1'b0, d, e, s);
                got[b] = d;
                if (e !== 1'b1) miss++;
                if (!s) unsteady++;
            end
            chk(got === page_m[(start + k) % 256], {tag, " data"}, int'(got),
                int'(page_m[(start + k) % 256]));
            chk(miss == 0 && unsteady == 0, {tag, " R11 oe/steady"}, miss + unsteady, 0);
        end
    endtask

    task automatic released_check(input int nbits, input string tag);
        int hits;
        logic d, e, s;
        hits = 0;
        for (int i = 0; i < nbits; i++) begin
            bit_xfer(1'b0, d, e, s);
            if (e !== 1'b0) hits++;
        end
        chk(hits == 0, tag, hits, 0);
    endtask

    task automatic end_cs(input string tag);
        cs_n = 1'b1;
        busy = 1'b0;
        #1;
        chk(oe === 1'b0, {tag, " R10 release"}, int'(oe), 0);
        repeat (2 * H) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] hi;
        logic d, e, s;
        for (int i = 0; i < 256; i++) page_m[i] = 8'((i * 37 + 11) % 256);
        repeat (4) @(negedge clk);
        chk(oe === 1'b0, "R1 reset oe", int'(oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(oe === 1'b0, "R1 idle oe", int'(oe), 0);
        for (int i = 0; i < 256; i++) preload(i, page_m[i]);

        // R2 R5 R4: start address sweep with scrambled ignored bits.
        for (int st = 0; st < 256; st += 3) begin
            hi = 16'((st * 613) ^ 16'h5A5A) & 16'hFFFB;
            header(8'h83, {hi, 8'(st)}, 1'b0, 1'b0, "R2 sweep");
            read_check(st, 2, "R2 R5 R4 sweep");
            end_cs("sweep");
        end

        // R3 R4: long stream across the wrap.
        header(8'h83, 24'h00_00FA, 1'b0, 1'b0, "R3 long");
        read_check(250, 12, "R3 R4 long");
        end_cs("long");

        // R6: lock bit set, with and without other high bits.
        header(8'h83, 24'h00_0412, 1'b0, 1'b0, "R6 a");
        released_check(24, "R6 bit10 released");
        end_cs("R6 a");
        header(8'h83, 24'hFF_FF00, 1'b0, 1'b0, "R6 b");
        released_check(16, "R6 all-high released");
        end_cs("R6 b");

        // R7: foreign opcodes, including every single-bit neighbour of 0x83.
        for (int op = 0; op < 256; op += 3) begin
            if (op == 8'h83) continue;
            header(8'(op), 24'h00_0020, 1'b0, 1'b0, "R7 op");
            released_check(8, "R7 opcode released");
            end_cs("R7");
        end
        for (int b = 0; b < 8; b++) begin
            header(8'h83 ^ 8'(1 << b), 24'h00_0005, 1'b0, 1'b0, "R7 flip");
            released_check(8, "R7 flip released");
            end_cs("R7 flip");
        end

        // R8: busy at decode rejects; busy only later does not.
        header(8'h83, 24'h00_0030, 1'b1, 1'b1, "R8 busy");
        released_check(16, "R8 busy released");
        end_cs("R8 busy");
        header(8'h83, 24'h00_0031, 1'b0, 1'b1, "R8 late");
        read_check(49, 2, "R8 late busy ignored");
        end_cs("R8 late");

        // R10: abort mid-byte, then a fresh transaction.
        header(8'h83, 24'h00_0028, 1'b0, 1'b0, "R10 abort");
        for (int i = 0; i < 3; i++) bit_xfer(1'b0, d, e, s);
        end_cs("R10 mid-byte");
        chk(oe === 1'b0, "R10 still released", int'(oe), 0);
        header(8'h83, 24'h00_0029, 1'b0, 1'b0, "R10 restart");
        read_check(41, 1, "R10 restart");
        end_cs("R10 restart");

        // R12: preload replaces a byte.
        preload(77, 8'hC3);
        header(8'h83, 24'h00_004D, 1'b0, 1'b0, "R12");
        read_check(77, 2, "R12 preload");
        end_cs("R12");
        chk(page_m[77] == 8'hC3, "R12 model", int'(page_m[77]), 8'hC3);

        finish_run();
    end
endmodule